// File: doc/BRIEF.md
# Subroutine Call and Return Sequencer

This block carries out three control-transfer operations for a small CPU with 16-bit addresses. The three operations are an indirect call through a table in the lowest 256 bytes of memory, a plain subroutine return, and a return from an exception handler. The decoder outside the block presents a two-bit operation code and an 8-bit table address. The block then owns the whole sequence. It adjusts the stack pointer, pushes or pops words, fetches the call target, and updates the program counter and the condition-code register.

Memory is reached through one request/acknowledge port that moves a 16-bit word at a time. Words sit big-endian at even byte addresses, so the memory side places the high byte at the lower address. The block holds `busy` for the whole operation and pulses `done` in its last cycle. While it is busy it takes no new operation. With a zero-wait memory, the operation always lasts the number of states that the instruction timing gives.

Top module: `call_ret_seq`

## Requirements
- R1: An operation code of 2'b01 (call) first lowers the stack pointer by 2, modulo 2^16, so a call from 0x0000 pushes at 0xFFFE. It then issues one write (`mem_we`=1) at the new stack pointer that carries the program counter held before the call. A call is the only operation that writes memory.
- R2: After its push, a call reads the word at the table address zero-extended to 16 bits and loads it into the program counter. The table address is sampled in the cycle the operation is accepted.
- R3: An operation code of 2'b10 (return) reads the word at the current stack pointer into the program counter, then raises the stack pointer by 2.
- R4: An operation code of 2'b11 (exception return) reads the word at the stack pointer and loads its low byte into the condition-code register. It then adds 2 to the stack pointer, reads the next word into the program counter, and adds 2 again.
- R5: With memory that acknowledges in the same cycle as the request, `busy` stays high for exactly 8 cycles for a call or a return and exactly 10 for an exception return. `done` is high only in the last of those cycles, and for one cycle only.
- R6: A call or a return leaves the condition-code register unchanged.
- R7: `op_valid` is ignored while `busy` is high, and it is also ignored with operation code 2'b00. No memory request is made while idle.
- R8: Reset clears the program counter, the stack pointer and the condition-code register to 0, and leaves `busy`, `done` and `mem_req` low.
- R9: A request that is not acknowledged is held with the same address, direction and write data until it is acknowledged. Wait states never shorten an operation below its nominal length, and they do not change its results.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid | input | 1 | Operation present on `op_kind` |
| op_kind | input | 2 | 01 call, 10 return, 11 exception return, 00 none |
| vec_addr | input | 8 | Byte address of the call target word in the low page |
| busy | output | 1 | Sequencer executing an operation |
| done | output | 1 | One-cycle pulse in the final state |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 for a write, 0 for a read |
| mem_addr | output | 16 | Byte address of the word accessed |
| mem_wdata | output | 16 | Word to be written |
| mem_rdata | input | 16 | Word read, valid with `mem_ack` |
| mem_ack | input | 1 | Access completes in this cycle |
| pc | output | 16 | Program counter |
| sp | output | 16 | Stack pointer |
| ccr | output | 8 | Condition-code register |

## Verification
The checker watches several rules in every cycle. Only a call may write. The stack pointer must end each operation displaced by exactly -2, +2 or +4 from its value at acceptance. `done` must be a single-cycle pulse that comes no sooner than the nominal state count. Pending requests must hold steady, no request may appear while idle, and the flags must not move during a call or a return. Other behaviour shows only in the bench's scenarios: which words land at which addresses, the order of the two pops in an exception return, the exact state counts with zero-wait memory, the wrap of the stack pointer below zero, and the results under wait states.

// File: rtl/crs_pkg.sv
package crs_pkg;

    typedef enum logic [1:0] {
        OP_NONE = 2'b00,
        OP_CALL = 2'b01,
        OP_RET  = 2'b10,
        OP_RTE  = 2'b11
    } op_e;

    typedef enum logic [2:0] {
        U_SPDEC,
        U_PUSHPC,
        U_LDVEC,
        U_POPPC,
        U_POPCCR,
        U_SPINC,
        U_END
    } uop_e;

    typedef enum logic [1:0] {
        S_IDLE,
        S_RUN,
        S_DONE
    } st_e;

    localparam int STEP_W = 3;

endpackage

// File: rtl/crs_uop_decode.sv
module crs_uop_decode
    import crs_pkg::*;
(
    input  op_e               op,
    input  logic [STEP_W-1:0] step,
    output uop_e              uop
);

    always_comb begin
        uop = U_END;
        unique case (op)
            OP_CALL: begin
                unique case (step)
                    3'd0:    uop = U_SPDEC;
                    3'd1:    uop = U_PUSHPC;
                    3'd2:    uop = U_LDVEC;
                    default: uop = U_END;
                endcase
            end
            OP_RET: begin
                unique case (step)
                    3'd0:    uop = U_POPPC;
                    3'd1:    uop = U_SPINC;
                    default: uop = U_END;
                endcase
            end
            OP_RTE: begin
                unique case (step)
                    3'd0:    uop = U_POPCCR;
                    3'd1:    uop = U_SPINC;
                    3'd2:    uop = U_POPPC;
                    3'd3:    uop = U_SPINC;
                    default: uop = U_END;
                endcase
            end
            default: uop = U_END;
        endcase
    end

endmodule

// File: rtl/crs_sp_alu.sv
module crs_sp_alu #(
    parameter int AW         = 16,
    parameter int WORD_BYTES = 2
) (
    input  logic [AW-1:0] sp,
    output logic [AW-1:0] sp_dec,
    output logic [AW-1:0] sp_inc
);

    localparam logic [AW-1:0] STEP = AW'(WORD_BYTES);

    assign sp_dec = sp - STEP;
    assign sp_inc = sp + STEP;

endmodule

// File: rtl/crs_mem_port.sv
module crs_mem_port
    import crs_pkg::*;
#(
    parameter int AW = 16,
    parameter int VW = 8
) (
    input  logic          run,
    input  uop_e          uop,
    input  logic [AW-1:0] sp,
    input  logic [AW-1:0] pc,
    input  logic [VW-1:0] vec,
    output logic          req,
    output logic          we,
    output logic [AW-1:0] addr,
    output logic [AW-1:0] wdata
);

    localparam int PAD_W = AW - VW;

    logic [AW-1:0] vec_ext;

    generate
        if (PAD_W > 0) begin : g_pad
            assign vec_ext = {{PAD_W{1'b0}}, vec};
        end else begin : g_nopad
            assign vec_ext = vec[AW-1:0];
        end
    endgenerate

    always_comb begin
        req   = 1'b0;
        we    = 1'b0;
        addr  = sp;
        wdata = '0;
        if (run) begin
            unique case (uop)
                U_PUSHPC: begin
                    req   = 1'b1;
                    we    = 1'b1;
                    addr  = sp;
                    wdata = pc;
                end
                U_LDVEC: begin
                    req  = 1'b1;
                    addr = vec_ext;
                end
                U_POPPC, U_POPCCR: begin
                    req  = 1'b1;
                    addr = sp;
                end
                default: begin
                    req = 1'b0;
                end
            endcase
        end
    end

endmodule

// File: rtl/call_ret_seq.sv
module call_ret_seq
    import crs_pkg::*;
#(
    parameter int AW          = 16,
    parameter int VW          = 8,
    parameter int CW          = 8,
    parameter int WORD_BYTES  = 2,
    parameter int CALL_STATES = 8,
    parameter int RET_STATES  = 8,
    parameter int RTE_STATES  = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          op_valid,
    input  logic [1:0]    op_kind,
    input  logic [VW-1:0] vec_addr,
    output logic          busy,
    output logic          done,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [AW-1:0] mem_wdata,
    input  logic [AW-1:0] mem_rdata,
    input  logic          mem_ack,
    output logic [AW-1:0] pc,
    output logic [AW-1:0] sp,
    output logic [CW-1:0] ccr
);

    localparam int MAX_STATES = (RTE_STATES > CALL_STATES) ?
        ((RTE_STATES > RET_STATES) ? RTE_STATES : RET_STATES) :
        ((CALL_STATES > RET_STATES) ? CALL_STATES : RET_STATES);
    localparam int CNT_W = $clog2(MAX_STATES + 1) + 1;
    localparam logic [CNT_W-1:0] CALL_LAST = CNT_W'(CALL_STATES - 1);
    localparam logic [CNT_W-1:0] RET_LAST  = CNT_W'(RET_STATES - 1);
    localparam logic [CNT_W-1:0] RTE_LAST  = CNT_W'(RTE_STATES - 1);
    localparam logic [CNT_W-1:0] CNT_MAX   = '1;

    typedef struct packed {
        st_e               st;
        op_e               op;
        logic [STEP_W-1:0] step;
        logic [CNT_W-1:0]  cyc;
        logic [VW-1:0]     vec;
        logic [AW-1:0]     sp;
        logic [AW-1:0]     pc;
        logic [CW-1:0]     ccr;
    } regs_t;

    regs_t r_q, r_d;

    uop_e          uop;
    logic [AW-1:0] sp_dec;
    logic [AW-1:0] sp_inc;
    logic          run;
    logic [CNT_W-1:0] last_cyc;

    crs_uop_decode u_dec (
        .op   (r_q.op),
        .step (r_q.step),
        .uop  (uop)
    );

    crs_sp_alu #(
        .AW         (AW),
        .WORD_BYTES (WORD_BYTES)
    ) u_alu (
        .sp     (r_q.sp),
        .sp_dec (sp_dec),
        .sp_inc (sp_inc)
    );

    assign run = (r_q.st == S_RUN);

    crs_mem_port #(
        .AW (AW),
        .VW (VW)
    ) u_port (
        .run   (run),
        .uop   (uop),
        .sp    (r_q.sp),
        .pc    (r_q.pc),
        .vec   (r_q.vec),
        .req   (mem_req),
        .we    (mem_we),
        .addr  (mem_addr),
        .wdata (mem_wdata)
    );

    always_comb begin
        unique case (r_q.op)
            OP_CALL: last_cyc = CALL_LAST;
            OP_RET:  last_cyc = RET_LAST;
            OP_RTE:  last_cyc = RTE_LAST;
            default: last_cyc = CALL_LAST;
        endcase
    end

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            S_IDLE: begin
                if (op_valid && (op_e'(op_kind) != OP_NONE)) begin
                    r_d.st   = S_RUN;
                    r_d.op   = op_e'(op_kind);
                    r_d.step = '0;
                    r_d.cyc  = CNT_W'(1);
                    r_d.vec  = vec_addr;
                end
            end
            S_RUN: begin
                if (r_q.cyc != CNT_MAX) begin
                    r_d.cyc = r_q.cyc + CNT_W'(1);
                end
                unique case (uop)
                    U_SPDEC: begin
                        r_d.sp   = sp_dec;
                        r_d.step = r_q.step + STEP_W'(1);
                    end
                    U_SPINC: begin
                        r_d.sp   = sp_inc;
                        r_d.step = r_q.step + STEP_W'(1);
                    end
                    U_PUSHPC: begin
                        if (mem_ack) begin
                            r_d.step = r_q.step + STEP_W'(1);
                        end
                    end
                    U_LDVEC, U_POPPC: begin
                        if (mem_ack) begin
                            r_d.pc   = mem_rdata;
                            r_d.step = r_q.step + STEP_W'(1);
                        end
                    end
                    U_POPCCR: begin
                        if (mem_ack) begin
                            r_d.ccr  = mem_rdata[CW-1:0];
                            r_d.step = r_q.step + STEP_W'(1);
                        end
                    end
                    default: begin
                        if (r_q.cyc >= last_cyc) begin
                            r_d.st = S_DONE;
                        end
                    end
                endcase
            end
            S_DONE: begin
                r_d.st = S_IDLE;
            end
            default: begin
                r_d.st = S_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st   <= S_IDLE;
            r_q.op   <= OP_NONE;
            r_q.step <= '0;
            r_q.cyc  <= '0;
            r_q.vec  <= '0;
            r_q.sp   <= '0;
            r_q.pc   <= '0;
            r_q.ccr  <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy = (r_q.st != S_IDLE);
    assign done = (r_q.st == S_DONE);
    assign pc   = r_q.pc;
    assign sp   = r_q.sp;
    assign ccr  = r_q.ccr;

endmodule

// File: rtl/crs_seq_chk.sv
module crs_seq_chk #(
    parameter int AW          = 16,
    parameter int CW          = 8,
    parameter int WORD_BYTES  = 2,
    parameter int CALL_STATES = 8,
    parameter int RET_STATES  = 8,
    parameter int RTE_STATES  = 10
) (
    input logic          clk,
    input logic          rst_n,
    input logic          op_valid,
    input logic [1:0]    op_kind,
    input logic          busy,
    input logic          done,
    input logic          mem_req,
    input logic          mem_we,
    input logic [AW-1:0] mem_addr,
    input logic [AW-1:0] mem_wdata,
    input logic          mem_ack,
    input logic [AW-1:0] sp,
    input logic [CW-1:0] ccr
);

    localparam logic [AW-1:0] WB  = AW'(WORD_BYTES);
    localparam logic [AW-1:0] WB2 = AW'(2 * WORD_BYTES);

    logic [1:0]    lat_kind;
    logic [AW-1:0] sp_start;
    logic [7:0]    bcnt;
    logic [7:0]    nominal;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_kind <= 2'b00;
            sp_start <= '0;
            bcnt     <= '0;
        end else if (op_valid && !busy && (op_kind != 2'b00)) begin
            lat_kind <= op_kind;
            sp_start <= sp;
            bcnt     <= 8'd1;
        end else if (busy && (bcnt != 8'hFF)) begin
            bcnt <= bcnt + 8'd1;
        end
    end

    always_comb begin
        unique case (lat_kind)
            2'b01:   nominal = 8'(CALL_STATES);
            2'b10:   nominal = 8'(RET_STATES);
            2'b11:   nominal = 8'(RTE_STATES);
            default: nominal = 8'd0;
        endcase
    end

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R5
    AST_DONE_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy); // R5
    AST_MIN_STATES: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (bcnt >= nominal)); // R9
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata))); // R9
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req); // R7
    AST_WRITE_ONLY_CALL: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> (lat_kind == 2'b01)); // R1
    AST_CALL_SP: assert property (@(posedge clk) disable iff (!rst_n)
        (done && lat_kind == 2'b01) |-> (sp == sp_start - WB)); // R1
    AST_RET_SP: assert property (@(posedge clk) disable iff (!rst_n)
        (done && lat_kind == 2'b10) |-> (sp == sp_start + WB)); // R3
    AST_RTE_SP: assert property (@(posedge clk) disable iff (!rst_n)
        (done && lat_kind == 2'b11) |-> (sp == sp_start + WB2)); // R4
    AST_FLAGS_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && lat_kind != 2'b11) |=> $stable(ccr)); // R6

endmodule

bind call_ret_seq crs_seq_chk #(
    .AW          (AW),
    .CW          (CW),
    .WORD_BYTES  (WORD_BYTES),
    .CALL_STATES (CALL_STATES),
    .RET_STATES  (RET_STATES),
    .RTE_STATES  (RTE_STATES)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_valid  (op_valid),
    .op_kind   (op_kind),
    .busy      (busy),
    .done      (done),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_ack   (mem_ack),
    .sp        (sp),
    .ccr       (ccr)
);

// File: tb/call_ret_seq_tb.sv
module call_ret_seq_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [1:0]  op_kind = 2'b00;
    logic [7:0]  vec_addr = 8'h00;
    logic        busy, done, mem_req, mem_we, mem_ack;
    logic [15:0] mem_addr, mem_wdata, mem_rdata, pc, sp;
    logic [7:0]  ccr;

    always #4 clk = ~clk;

    call_ret_seq u_dut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_kind(op_kind),
        .vec_addr(vec_addr), .busy(busy), .done(done), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ack(mem_ack), .pc(pc), .sp(sp), .ccr(ccr)
    );

    // word memory: low page and top page of the address space
    logic [15:0] mem [0:511];
    logic [3:0]  wait_cfg = 4'd0;
    logic [3:0]  wcnt = 4'd0;

    function automatic logic [8:0] widx(input logic [15:0] a);
        return {a[15], a[8:1]};
    endfunction

    assign mem_rdata = mem[widx(mem_addr)];
    assign mem_ack   = mem_req && (wcnt >= wait_cfg);

    always @(posedge clk) begin
        if (!mem_req || mem_ack) wcnt <= 4'd0;
        else wcnt <= wcnt + 4'd1;
        if (mem_req && mem_ack && mem_we) mem[widx(mem_addr)] <= mem_wdata;
    end

    // bus and timing log
    logic        clr = 1'b0;
    int          nacc, bcount, dcount;
    logic [15:0] log_addr [0:3];
    logic        log_we   [0:3];
    logic [15:0] log_data [0:3];

    always @(posedge clk) begin
        if (clr) begin
            nacc <= 0; bcount <= 0; dcount <= 0;
        end else begin
            if (busy) bcount <= bcount + 1;
            if (done) dcount <= dcount + 1;
            if (mem_req && mem_ack && nacc < 4) begin
                log_addr[nacc] <= mem_addr;
                log_we[nacc]   <= mem_we;
                log_data[nacc] <= mem_we ? mem_wdata : mem_rdata;
                nacc <= nacc + 1;
            end
        end
    end

    int total = 0;
    int fails = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic run_op(input logic [1:0] k, input logic [7:0] v, input bit inj);
        @(negedge clk) clr = 1'b1;
        @(negedge clk) clr = 1'b0;
        op_valid = 1'b1; op_kind = k; vec_addr = v;
        @(negedge clk) op_valid = 1'b0; op_kind = 2'b00; vec_addr = 8'h00;
        for (int n = 0; n < 100 && dcount == 0; n++) begin
            if (inj && n == 2) begin
                op_valid = 1'b1; op_kind = 2'b10; vec_addr = 8'h20;
            end else begin
                op_valid = 1'b0; op_kind = 2'b00;
            end
            @(negedge clk);
        end
        op_valid = 1'b0; op_kind = 2'b00;
        chk("R5 done pulse count", dcount, 1);
    endtask

    typedef struct packed {
        logic [1:0]  op;
        logic [7:0]  vec;
        logic [15:0] pc;
        logic [15:0] sp;
        logic [7:0]  ccr;
        logic [7:0]  st;
        logic [2:0]  na;
        logic [15:0] a0;
        logic        w0;
        logic [15:0] d0;
        logic [15:0] a1;
    } row_t;

    localparam int NROWS = 7;
    localparam row_t TBL [NROWS] = '{
        '{2'b01, 8'h10, 16'h1234, 16'hFFFE, 8'h00, 8'd8,  3'd2, 16'hFFFE, 1'b1, 16'h0000, 16'h0010},
        '{2'b01, 8'h20, 16'hABCD, 16'hFFFC, 8'h00, 8'd8,  3'd2, 16'hFFFC, 1'b1, 16'h1234, 16'h0020},
        '{2'b10, 8'h00, 16'h1234, 16'hFFFE, 8'h00, 8'd8,  3'd1, 16'hFFFC, 1'b0, 16'h1234, 16'h0000},
        '{2'b10, 8'h55, 16'h0000, 16'h0000, 8'h00, 8'd8,  3'd1, 16'hFFFE, 1'b0, 16'h0000, 16'h0000},
        '{2'b11, 8'h00, 16'h4321, 16'h0004, 8'hC3, 8'd10, 3'd2, 16'h0000, 1'b0, 16'h5AC3, 16'h0002},
        '{2'b01, 8'h10, 16'h1234, 16'h0002, 8'hC3, 8'd8,  3'd2, 16'h0002, 1'b1, 16'h4321, 16'h0010},
        '{2'b10, 8'h00, 16'h4321, 16'h0004, 8'hC3, 8'd8,  3'd1, 16'h0002, 1'b0, 16'h4321, 16'h0000}
    };

    function automatic string tag_of(input logic [1:0] k);
        case (k)
            2'b01:   return "R1";
            2'b10:   return "R3";
            default: return "R4";
        endcase
    endfunction

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        total++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin : main
        for (int i = 0; i < 512; i++) mem[i] = 16'h0000;
        mem[widx(16'h0010)] = 16'h1234;
        mem[widx(16'h0020)] = 16'hABCD;
        mem[widx(16'h0000)] = 16'h5AC3;
        mem[widx(16'h0002)] = 16'h4321;
        mem[widx(16'h0004)] = 16'h00FF;
        mem[widx(16'h0006)] = 16'h0BEE;

        repeat (3) @(negedge clk);
        chk("R8 reset pc", pc, 16'h0000);
        chk("R8 reset sp", sp, 16'h0000);
        chk("R8 reset ccr", ccr, 8'h00);
        chk("R8 reset busy/done/req", {busy, done, mem_req}, 3'b000);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NROWS; i++) begin
            string t;
            t = tag_of(TBL[i].op);
            run_op(TBL[i].op, TBL[i].vec, 1'b0);
            chk((TBL[i].op == 2'b01) ? "R2 pc after call" : {t, " pc"}, pc, TBL[i].pc);
            chk({t, " sp"}, sp, TBL[i].sp);
            chk((TBL[i].op == 2'b11) ? "R4 ccr" : "R6 ccr kept", ccr, TBL[i].ccr);
            chk("R5 busy states", bcount, TBL[i].st);
            chk({t, " access count"}, nacc, TBL[i].na);
            chk({t, " first addr"}, log_addr[0], TBL[i].a0);
            chk({t, " first dir"}, log_we[0], TBL[i].w0);
            chk({t, " first data"}, log_data[0], TBL[i].d0);
            if (TBL[i].na > 1) begin
                chk((TBL[i].op == 2'b01) ? "R2 vector addr" : "R4 second pop addr",
                    log_addr[1], TBL[i].a1);
                chk((TBL[i].op == 2'b01) ? "R1 no second write" : "R4 second pop read",
                    log_we[1], 1'b0);
            end
        end

        // R7: op code 00 while idle is ignored
        @(negedge clk) op_valid = 1'b1; op_kind = 2'b00;
        @(negedge clk) op_valid = 1'b0;
        chk("R7 none op stays idle", {busy, mem_req}, 2'b00);

        // R7: a return offered while a call runs is ignored
        run_op(2'b01, 8'h20, 1'b1);
        chk("R7 pc unaffected by injected op", pc, 16'hABCD);
        chk("R7 sp unaffected by injected op", sp, 16'h0002);
        chk("R7 access count", nacc, 2);
        chk("R7 busy length", bcount, 8);
        chk("R1 pushed pc", log_data[0], 16'h4321);
        @(negedge clk);
        chk("R7 idle after done", busy, 1'b0);

        // R9: wait states on every access
        wait_cfg = 4'd3;
        run_op(2'b10, 8'h00, 1'b0);
        chk("R9 ret pc with waits", pc, 16'h4321);
        chk("R9 ret sp with waits", sp, 16'h0004);
        chk("R9 ret not shorter", bcount >= 8, 1'b1);
        run_op(2'b11, 8'h00, 1'b0);
        chk("R9 rte ccr with waits", ccr, 8'hFF);
        chk("R9 rte pc with waits", pc, 16'h0BEE);
        chk("R9 rte sp with waits", sp, 16'h0008);
        chk("R9 rte stretched", bcount > 10, 1'b1);
        chk("R4 pop order with waits", {log_addr[0], log_addr[1]}, {16'h0004, 16'h0006});
        wait_cfg = 4'd0;

        // R8: reset in the middle of an operation
        @(negedge clk) op_valid = 1'b1; op_kind = 2'b01; vec_addr = 8'h10;
        @(negedge clk) op_valid = 1'b0; op_kind = 2'b00;
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R8 mid-op reset pc", pc, 16'h0000);
        chk("R8 mid-op reset sp", sp, 16'h0000);
        chk("R8 mid-op reset ccr", ccr, 8'h00);
        chk("R8 mid-op reset idle", {busy, done, mem_req}, 3'b000);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule